// File: doc/BRIEF.md
# Coefficient and Gamma Loading Port

This block is the host-facing loader for the per-pixel correction memories of an image sensor front end. The host reaches it through four byte-wide registers picked by a 2-bit select: a mode register, two address registers and a data register. Each data byte the host writes becomes a memory write strobe on the memory side. Every write carries the current address, a word, a target code (offset, gain or gamma) and a colour code.

In the two coefficient targets a 16-bit entry takes two data-register writes. The first (low) byte is held in a staging register. The memory write and the address advance happen only on the second (high) byte. In the gamma target each byte is its own entry, so every data write stores and advances. The mode register also reports an external pause flag on a bit that host writes cannot change. A direction bit next to the high address bits blocks data-register stores when it is set.

Top module: `coef_gamma_port`

## Requirements
- R1: After reset the address is 0, the target is offset (code 00), the colour is 0, the direction bit is 0 and the byte phase is the first byte.
- R2: Host register select codes are: 0 mode, 1 address low byte, 2 address high part, 3 data. The mode byte is laid out as {3'b0, colour[1:0], target[1:0], pause}. Bit 0 always reads the level of `pause_in`, and the value written to bit 0 has no effect.
- R3: With target 00 (offset) or 01 (gain), the first data byte raises no memory write and leaves the address unchanged. The second data byte raises `mem_we` with `mem_wdata` = {second byte, first byte} at the current address, and the address then advances by one.
- R4: With target 10 or 11 (gamma), every data byte raises `mem_we` with `mem_wdata` = {8'h00, byte} at the current address, and the address then advances by one.
- R5: The address is 14 bits. Select 1 writes bits 7:0. Select 2 writes bits 13:8 from data bits 5:0 and the direction bit from data bit 6. Data bit 7 is ignored and reads back as 0.
- R6: Any write to the mode register or to either address register returns the byte phase to the first byte. A dangling coefficient low byte is then discarded.
- R7: The address advance wraps from 0x3FFF to 0x0000.
- R8: While the direction bit is 1, data-register writes raise no memory write and do not move the address.
- R9: `mem_target` and `mem_color` follow the mode register fields in every target mode. The colour applies to gamma stores as well as coefficient stores.
- R10: `host_rdata` is 0 whenever `host_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Register select: 0 mode, 1 address low, 2 address high, 3 data |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, 0 when not reading |
| pause_in | input | 1 | External pause status shown in mode bit 0 |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 14 | Memory address, equal to the address register |
| mem_wdata | output | 16 | Memory write word |
| mem_target | output | 2 | Target code from the mode register |
| mem_color | output | 2 | Colour code from the mode register |

## Verification
The bench builds the block with its default widths: a 14-bit address and byte-wide host data. At these widths two address-register writes place the pointer at 0x3FFF, so the wrap to zero can be checked directly in both gamma and coefficient modes. A table of host writes walks a store sequence that crosses target switches and an address reload in the middle of a word. Directed tests then cover the read-only pause bit, the direction block and the ignored high data bit.

// File: rtl/coef_gamma_port.sv
module coef_gamma_port #(
  parameter int ADDR_W = 14,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          host_sel,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [BYTE_W-1:0]   host_wdata,
  output logic [BYTE_W-1:0]   host_rdata,
  input  logic                pause_in,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*BYTE_W-1:0] mem_wdata,
  output logic [1:0]          mem_target,
  output logic [1:0]          mem_color
);
  localparam int HI_W = ADDR_W - BYTE_W;
  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_ALO  = 2'd1;
  localparam logic [1:0] SEL_AHI  = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] stage_q;
  logic [1:0]        target_q, color_q;
  logic              dir_q, phase_q;

  wire gamma_mode = target_q[1];
  wire data_wr    = host_wr && host_sel == SEL_DATA && !dir_q;
  wire ctrl_wr    = host_wr && host_sel != SEL_DATA;
  wire store      = data_wr && (gamma_mode || phase_q);

  assign mem_we     = store;
  assign mem_addr   = addr_q;
  assign mem_wdata  = gamma_mode ? {{BYTE_W{1'b0}}, host_wdata} : {host_wdata, stage_q};
  assign mem_target = target_q;
  assign mem_color  = color_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stage_q  <= '0;
      target_q <= 2'b00;
      color_q  <= 2'b00;
      dir_q    <= 1'b0;
      phase_q  <= 1'b0;
    end else begin
      if (ctrl_wr) phase_q <= 1'b0;
      if (host_wr && host_sel == SEL_MODE) begin
        target_q <= host_wdata[2:1];
        color_q  <= host_wdata[4:3];
      end
      if (host_wr && host_sel == SEL_ALO) addr_q[BYTE_W-1:0] <= host_wdata;
      if (host_wr && host_sel == SEL_AHI) begin
        addr_q[ADDR_W-1:BYTE_W] <= host_wdata[HI_W-1:0];
        dir_q <= host_wdata[HI_W];
      end
      if (data_wr && !gamma_mode && !phase_q) begin
        stage_q <= host_wdata;
        phase_q <= 1'b1;
      end
      if (store) begin
        addr_q  <= addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
        phase_q <= 1'b0;
      end
    end
  end

  logic [BYTE_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (host_sel)
      SEL_MODE: rd_mux[4:0] = {color_q, target_q, pause_in};
      SEL_ALO:  rd_mux = addr_q[BYTE_W-1:0];
      SEL_AHI: begin
        rd_mux[HI_W-1:0] = addr_q[ADDR_W-1:BYTE_W];
        rd_mux[HI_W]     = dir_q;
      end
      default:  rd_mux = '0;
    endcase
  end
  assign host_rdata = host_rd ? rd_mux : '0;
endmodule

module coef_gamma_port_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [1:0]        host_sel,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_target,
  input logic              dir_q,
  input logic              phase_q
);
  // R3
  coef_first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd3 && !dir_q && !mem_target[1] && !phase_q
    |=> mem_addr == $past(mem_addr) && phase_q);
  // R3
  coef_store_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !mem_target[1] |-> phase_q);
  // R4 R7
  gamma_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd3 && !dir_q && mem_target[1]
    |=> mem_addr == $past(mem_addr) + 1'b1);
  // R6
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel != 2'd3 |=> !phase_q);
  // R8
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd3 && dir_q |=> mem_addr == $past(mem_addr));
endmodule

bind coef_gamma_port coef_gamma_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_target(mem_target),
  .dir_q(dir_q), .phase_q(phase_q)
);

// File: tb/coef_gamma_port_bench.sv
module coef_gamma_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_sel = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0, pause_in = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        mem_we;
  logic [13:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [1:0]  mem_target, mem_color;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  coef_gamma_port u_coef_gamma_port (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    #2;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wr_chk(string tag, logic [1:0] s, logic [7:0] d,
                        logic exp_we, logic [15:0] exp_w, logic [13:0] exp_a0);
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    #2;
    check({tag, " we"}, 32'(mem_we), 32'(exp_we));
    check({tag, " addr"}, 32'(mem_addr), 32'(exp_a0));
    if (exp_we) check({tag, " wdata"}, 32'(mem_wdata), 32'(exp_w));
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [1:0] s, logic [7:0] exp);
    host_sel = s; host_rd = 1'b1;
    #2;
    check(tag, 32'(host_rdata), 32'(exp));
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // {sel, byte, exp_we, exp_word, exp_addr_after}
  localparam logic [40:0] VEC [13] = '{
    {2'd1, 8'h10, 1'b0, 16'h0000, 14'h0010},
    {2'd3, 8'h34, 1'b0, 16'h0000, 14'h0010},
    {2'd3, 8'h12, 1'b1, 16'h1234, 14'h0011},
    {2'd3, 8'hCD, 1'b0, 16'h0000, 14'h0011},
    {2'd3, 8'hAB, 1'b1, 16'hABCD, 14'h0012},
    {2'd0, 8'h04, 1'b0, 16'h0000, 14'h0012},
    {2'd3, 8'h5A, 1'b1, 16'h005A, 14'h0013},
    {2'd3, 8'hFF, 1'b1, 16'h00FF, 14'h0014},
    {2'd0, 8'h02, 1'b0, 16'h0000, 14'h0014},
    {2'd3, 8'h11, 1'b0, 16'h0000, 14'h0014},
    {2'd1, 8'h20, 1'b0, 16'h0000, 14'h0020},
    {2'd3, 8'h22, 1'b0, 16'h0000, 14'h0020},
    {2'd3, 8'h33, 1'b1, 16'h3322, 14'h0021}
  };

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 mode", 2'd0, 8'h00);
    rd("R1 addr lo", 2'd1, 8'h00);
    rd("R1 addr hi", 2'd2, 8'h00);
    check("R1 target", 32'(mem_target), 0);

    // R3 R4 R6 table walk
    begin
      logic [13:0] a_prev = 14'h0;
      for (int i = 0; i < 13; i++) begin
        wr_chk($sformatf("R3/R4/R6 vec%0d", i), VEC[i][40:39], VEC[i][38:31],
               VEC[i][30], VEC[i][29:14], VEC[i][1:0] == 2'b00 && VEC[i][40:39] == 2'd1 ? a_prev : a_prev);
        check($sformatf("R3/R4 vec%0d addr after", i), 32'(mem_addr), 32'(VEC[i][13:0]));
        a_prev = VEC[i][13:0];
      end
    end

    // R2 pause read-only
    pause_in = 1'b1;
    wr(2'd0, 8'h1E);
    rd("R2 pause shows 1", 2'd0, 8'h1F);
    pause_in = 1'b0;
    wr(2'd0, 8'h1F);
    rd("R2 pause write ignored", 2'd0, 8'h1E);
    // R9 fields drive outputs
    check("R9 target", 32'(mem_target), 3);
    check("R9 color", 32'(mem_color), 3);
    wr(2'd0, 8'h0C);
    check("R9 gamma color", 32'(mem_color), 1);
    wr(2'd1, 8'h40);
    wr_chk("R9 gamma store", 2'd3, 8'h77, 1'b1, 16'h0077, 14'h0040);
    check("R9 color held", 32'(mem_color), 1);

    // R7 wrap gamma
    wr(2'd2, 8'h3F); wr(2'd1, 8'hFF);
    wr_chk("R7 gamma top", 2'd3, 8'h01, 1'b1, 16'h0001, 14'h3FFF);
    check("R7 gamma wrap", 32'(mem_addr), 0);
    // R7 wrap coefficient
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h3F); wr(2'd1, 8'hFF);
    wr_chk("R7 coef lo", 2'd3, 8'h55, 1'b0, 16'h0, 14'h3FFF);
    wr_chk("R7 coef hi", 2'd3, 8'h66, 1'b1, 16'h6655, 14'h3FFF);
    check("R7 coef wrap", 32'(mem_addr), 0);

    // R6 mode write drops pending low byte
    wr_chk("R6 lo", 2'd3, 8'h01, 1'b0, 16'h0, 14'h0000);
    wr(2'd0, 8'h00);
    wr_chk("R6 restart", 2'd3, 8'h02, 1'b0, 16'h0, 14'h0000);
    wr_chk("R6 pair", 2'd3, 8'h03, 1'b1, 16'h0302, 14'h0000);

    // R8 direction blocks stores
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h40); wr(2'd1, 8'h05);
    rd("R8 dir readback", 2'd2, 8'h40);
    wr_chk("R8 blocked", 2'd3, 8'h99, 1'b0, 16'h0, 14'h0005);
    check("R8 addr held", 32'(mem_addr), 5);

    // R5 high bit 7 ignored
    wr(2'd2, 8'hBF);
    rd("R5 hi readback", 2'd2, 8'h3F);
    rd("R5 lo readback", 2'd1, 8'h05);
    check("R5 mem_addr", 32'(mem_addr), 32'h3F05);

    // R10 idle read
    host_sel = 2'd2; #2;
    check("R10 idle rdata", 32'(host_rdata), 0);
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule